// File: doc/BRIEF.md
# Byte-wide SPI host port for an 8-bit processor bus

This block lets an 8-bit processor talk to SPI devices such as memory cards through three bus offsets. Software writes a control byte that enables the serial clock, picks its rate and selects one device. It places the outgoing byte in the data register and starts the exchange with a write to a separate strobe offset. It then polls a completion flag and reads the byte that came back from the data register.

The serial side runs in mode 0. SCK rests low, MOSI is presented most significant bit first and moves only while SCK is low, and MISO is captured on each rising SCK edge. One exchange is eight SCK periods long. Received data is held apart from the shift path, so the byte software reads stays valid until the next exchange finishes.

Top module: `spi_host`

## Requirements
- R1: After reset every chip select is high, SCK is low, MOSI is high, and a status read returns 0x08 (done set, busy clear).
- R2: Control bits [5:4] are chip-select enables. Bit 4 drives cs_no[0] low and bit 5 drives cs_no[1] low. When both are set, only cs_no[0] goes low. A control value of 0x00 releases every select.
- R3: The byte in the data register is sent on MOSI most significant bit first, one bit for each rising SCK edge.
- R4: Mode 0 applies. SCK is low while idle, MOSI changes only while SCK is low, and MISO is captured on the rising SCK edges.
- R5: Control bits [1:0] hold a value n that sets the SCK period to 2^(n+1) system clocks. The done flag sets exactly 16*2^n clocks after the clock edge that accepts the start strobe. The rate is captured at start.
- R6: A write to offset 2 with any data value starts one exchange when control bit 2 (clock enable) is 1. When bit 2 is 0 the write is ignored: no busy and no SCK edge.
- R7: A read of offset 0 returns busy in bit 0 and done in bit 3, with all other bits 0. Done clears at start and sets after the eighth SCK pulse has returned low. Busy is 1 for exactly that span.
- R8: A read of offset 1 returns the last completed received byte. It is unchanged during an exchange and updates at completion.
- R9: A start strobe that arrives during an exchange is ignored. The running exchange keeps its data and length, and no extra exchange follows it.
- R10: A write to offset 1 during an exchange leaves the bits being shifted untouched. The new byte is sent by the next exchange.
- R11: Reads of offsets 2 and 3 return 0x00. Reads have no side effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_i | input | 1 | Bus cycle valid |
| addr_i | input | 2 | Register offset |
| we_i | input | 1 | 1 = write, 0 = read |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_no | output | 2 | Chip selects, active low |

## Verification
The embedded checks assume that a bus access lasts a single clock with ce_i high and that MISO is already settled at the system clock edge where SCK goes high. The bench drives all bus signals on the falling system clock. Its device model moves MISO only after each rising SCK, so the capture edge always sees a stable bit. Rate changes are made only while the port is idle, and the assertions on divider spacing depend on that.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;
  localparam int unsigned BYTE_W        = 8;
  localparam int unsigned STAT_BUSY_BIT = 0;
  localparam int unsigned STAT_DONE_BIT = 3;
  localparam int unsigned CTRL_EN_BIT   = 2;
  localparam int unsigned CTRL_CS_LSB   = 4;

  typedef enum logic [1:0] {
    OFS_CTRL = 2'd0,
    OFS_DATA = 2'd1,
    OFS_GO   = 2'd2,
    OFS_NONE = 2'd3
  } reg_ofs_e;
endpackage

// File: rtl/spi_host_clkdiv.sv
module spi_host_clkdiv #(
  parameter int unsigned SEL_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             run_i,
  output logic             tick_o
);
  localparam int unsigned CNT_W = (1 << SEL_W) - 1;

  logic [SEL_W-1:0] sel_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;

  assign limit  = CNT_W'((32'd1 << sel_q) - 32'd1);
  assign tick_o = run_i && (cnt_q == limit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= '0;
      cnt_q <= '0;
    end else begin
      if (load_i) sel_q <= sel_i;
      if (load_i || !run_i)   cnt_q <= '0;
      else if (cnt_q == limit) cnt_q <= '0;
      else                     cnt_q <= cnt_q + 1'b1;
    end
  end

  // R5: rate is frozen for the whole exchange
  a_r5_rate_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !load_i) |=> $stable(sel_q) || !run_i);
  a_r5_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> cnt_q <= limit);
endmodule

// File: rtl/spi_host_shifter.sv
module spi_host_shifter #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         tick_i,
  input  logic [W-1:0] tx_i,
  input  logic         miso_i,
  output logic         busy_o,
  output logic         sck_o,
  output logic         mosi_o,
  output logic [W-1:0] rx_o,
  output logic         fin_o
);
  localparam int unsigned BC_W = $clog2(W);

  logic            busy_q, sck_q, mosi_q;
  logic [W-1:0]    sh_q, rx_sh_q;
  logic [BC_W-1:0] bit_q;
  logic            last;

  assign last  = (bit_q == BC_W'(W - 1));
  assign fin_o = busy_q && tick_i && sck_q && last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      sck_q   <= 1'b0;
      mosi_q  <= 1'b1;
      sh_q    <= '0;
      rx_sh_q <= '0;
      bit_q   <= '0;
    end else if (start_i && !busy_q) begin
      busy_q <= 1'b1;
      sck_q  <= 1'b0;
      sh_q   <= tx_i;
      mosi_q <= tx_i[W-1];
      bit_q  <= '0;
    end else if (busy_q && tick_i) begin
      if (!sck_q) begin
        sck_q   <= 1'b1;
        rx_sh_q <= {rx_sh_q[W-2:0], miso_i};
      end else begin
        sck_q <= 1'b0;
        if (last) begin
          busy_q <= 1'b0;
          mosi_q <= 1'b1;
        end else begin
          bit_q  <= bit_q + 1'b1;
          sh_q   <= sh_q << 1;
          mosi_q <= sh_q[W-2];
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign sck_o  = sck_q;
  assign mosi_o = mosi_q;
  assign rx_o   = rx_sh_q;

  a_r4_sck_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> !sck_q);
  a_r1_mosi_idle_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> mosi_q);
  a_r4_mosi_steady_high_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sck_q && $past(sck_q)) |-> $stable(mosi_q));
  a_r9_busy_until_fin: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !fin_o) |=> busy_q);
endmodule

// File: rtl/spi_host_regs.sv
module spi_host_regs
  import spi_host_pkg::*;
#(
  parameter int unsigned NUM_CS = 2,
  parameter int unsigned SEL_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_i,
  input  logic [1:0]        addr_i,
  input  logic              we_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  input  logic              busy_i,
  input  logic              fin_i,
  input  logic [BYTE_W-1:0] rx_i,
  output logic              start_o,
  output logic [SEL_W-1:0]  sel_o,
  output logic [BYTE_W-1:0] tx_o,
  output logic [NUM_CS-1:0] cs_no
);
  logic [BYTE_W-1:0] ctrl_q, tx_q, rx_q;
  logic              done_q;
  logic              wr;
  logic [NUM_CS-1:0] cs_act;
  logic              found;

  assign wr      = ce_i && we_i;
  assign start_o = wr && (addr_i == OFS_GO) && ctrl_q[CTRL_EN_BIT] && !busy_i;
  assign sel_o   = ctrl_q[SEL_W-1:0];
  assign tx_o    = tx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
      done_q <= 1'b1;
    end else begin
      if (wr && addr_i == OFS_CTRL) ctrl_q <= wdata_i;
      if (wr && addr_i == OFS_DATA) tx_q   <= wdata_i;
      if (start_o)    done_q <= 1'b0;
      else if (fin_i) done_q <= 1'b1;
      if (fin_i) rx_q <= rx_i;
    end
  end

  // lowest enabled select wins
  always_comb begin
    cs_act = '0;
    found  = 1'b0;
    for (int i = 0; i < NUM_CS; i++) begin
      if (ctrl_q[CTRL_CS_LSB+i] && !found) begin
        cs_act[i] = 1'b1;
        found     = 1'b1;
      end
    end
  end
  assign cs_no = ~cs_act;

  always_comb begin
    rdata_o = '0;
    case (reg_ofs_e'(addr_i))
      OFS_CTRL: begin
        rdata_o[STAT_BUSY_BIT] = busy_i;
        rdata_o[STAT_DONE_BIT] = done_q;
      end
      OFS_DATA: rdata_o = rx_q;
      default:  rdata_o = '0;
    endcase
  end

  a_r2_cs_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~cs_no));
  a_r7_done_busy_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_i && done_q));
  a_r8_rx_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !fin_i) |=> $stable(rx_q));
  a_r7_done_after_fin: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin_i |=> done_q && !busy_i);
endmodule

// File: rtl/spi_host.sv
module spi_host
  import spi_host_pkg::*;
#(
  parameter int unsigned NUM_CS = 2,
  parameter int unsigned SEL_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_i,
  input  logic [1:0]        addr_i,
  input  logic              we_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  output logic              sck_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic [NUM_CS-1:0] cs_no
);
  logic              start, tick, busy, fin;
  logic [SEL_W-1:0]  sel;
  logic [BYTE_W-1:0] tx, rx;

  spi_host_regs #(.NUM_CS(NUM_CS), .SEL_W(SEL_W)) u_regs (
    .clk_i, .rst_ni, .ce_i, .addr_i, .we_i, .wdata_i, .rdata_o,
    .busy_i(busy), .fin_i(fin), .rx_i(rx),
    .start_o(start), .sel_o(sel), .tx_o(tx), .cs_no
  );

  spi_host_clkdiv #(.SEL_W(SEL_W)) u_div (
    .clk_i, .rst_ni, .load_i(start), .sel_i(sel), .run_i(busy), .tick_o(tick)
  );

  spi_host_shifter #(.W(BYTE_W)) u_shift (
    .clk_i, .rst_ni, .start_i(start), .tick_i(tick), .tx_i(tx), .miso_i,
    .busy_o(busy), .sck_o, .mosi_o, .rx_o(rx), .fin_o(fin)
  );
endmodule

// File: tb/spi_host_test.sv
module spi_host_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ce = 1'b0, we = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       sck, mosi, miso;
  logic [1:0] cs_n;

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  int rc = 0;
  int mosi_viol = 0;
  logic [7:0] slv = '0;
  logic [7:0] cap = '0;
  logic [7:0] exp_q[$];
  bit finished = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  spi_host uut (
    .clk_i(clk), .rst_ni(rst_n), .ce_i(ce), .addr_i(addr), .we_i(we),
    .wdata_i(wdata), .rdata_o(rdata), .sck_o(sck), .mosi_o(mosi),
    .miso_i(miso), .cs_no(cs_n)
  );

  logic [2:0] rbit;
  assign rbit = 3'(rc);
  assign miso = slv[3'd7 - rbit];

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // monitor: device model capturing MOSI, scoreboard compare per byte (R3)
  always @(posedge sck) begin
    cap = {cap[6:0], mosi};
    rc  = rc + 1;
    if (rc % 8 == 0) begin
      if (exp_q.size() == 0) check(1'b0, "R9 unexpected byte", {24'd0, cap}, 32'd0);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        check(cap == e, "R3 mosi byte", {24'd0, cap}, {24'd0, e});
      end
    end
  end

  // R4: MOSI must not move while SCK stays high
  logic prev_sck = 1'b0, prev_mosi = 1'b1;
  always @(negedge clk) begin
    if (sck && prev_sck && mosi != prev_mosi) mosi_viol++;
    prev_sck  <= sck;
    prev_mosi <= mosi;
  end

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d, output int t);
    @(negedge clk);
    ce = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    #1 t = cyc;
    @(negedge clk);
    ce = 1'b0; we = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    ce = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // driver: push expected byte, strobe, poll, measure
  task automatic xfer(input logic [7:0] ctrl, input logic [7:0] tx, input logic [7:0] dev,
                      input logic [7:0] go_data, input bit load_tx);
    int t0, t;
    logic [7:0] s;
    int lim;
    bit saw_busy;
    bus_write(2'd0, ctrl, t);
    if (load_tx) bus_write(2'd1, tx, t);
    slv = dev;
    exp_q.push_back(tx);
    bus_write(2'd2, go_data, t0);
    saw_busy = 1'b0;
    lim = 0;
    do begin
      bus_read(2'd0, s);
      if (s[0]) saw_busy = 1'b1;
      lim++;
    end while (!s[3] && lim < 1000);
    t = cyc;
    check(saw_busy, "R7 busy seen", {31'd0, saw_busy}, 32'd1);
    check(t - t0 == 16 * (1 << ctrl[1:0]), "R5 duration",
          32'(t - t0), 32'(16 * (1 << ctrl[1:0])));
    check(s == 8'h08, "R7 status after done", {24'd0, s}, 32'h08);
    bus_read(2'd1, s);
    check(s == dev, "R8 rx byte", {24'd0, s}, {24'd0, dev});
  endtask

  initial begin
    logic [7:0] s;
    int t, t0, rc0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1
    bus_read(2'd0, s);
    check(s == 8'h08, "R1 status", {24'd0, s}, 32'h08);
    check(cs_n == 2'b11, "R1 cs", {30'd0, cs_n}, 32'h3);
    check(sck == 1'b0, "R1 sck", {31'd0, sck}, 32'd0);
    check(mosi == 1'b1, "R1 mosi", {31'd0, mosi}, 32'd1);

    // R2
    bus_write(2'd0, 8'h14, t); #1;
    check(cs_n == 2'b10, "R2 cs0", {30'd0, cs_n}, 32'h2);
    bus_write(2'd0, 8'h24, t); #1;
    check(cs_n == 2'b01, "R2 cs1", {30'd0, cs_n}, 32'h1);
    bus_write(2'd0, 8'h34, t); #1;
    check(cs_n == 2'b10, "R2 both set", {30'd0, cs_n}, 32'h2);
    bus_write(2'd0, 8'h00, t); #1;
    check(cs_n == 2'b11, "R2 release", {30'd0, cs_n}, 32'h3);

    // R6: strobe with clock disabled is ignored
    bus_write(2'd0, 8'h10, t);
    bus_write(2'd1, 8'h77, t);
    bus_write(2'd2, 8'h00, t);
    repeat (40) @(negedge clk);
    bus_read(2'd0, s);
    check(s == 8'h08, "R6 disabled strobe status", {24'd0, s}, 32'h08);
    check(rc == 0, "R6 no sck edges", 32'(rc), 32'd0);

    // R3 R4 R5 fastest rate
    xfer(8'h14, 8'hA5, 8'h3C, 8'h00, 1'b1);

    // R9 R10 R8: slowest rate, disturb mid-exchange
    bus_write(2'd0, 8'h27, t);
    bus_write(2'd1, 8'h81, t);
    slv = 8'hC3;
    exp_q.push_back(8'h81);
    bus_write(2'd2, 8'h55, t0);
    repeat (20) @(negedge clk);
    bus_write(2'd1, 8'h5E, t);
    bus_write(2'd2, 8'hAA, t);
    bus_read(2'd1, s);
    check(s == 8'h3C, "R8 rx held during exchange", {24'd0, s}, 32'h3C);
    do bus_read(2'd0, s); while (!s[3] && cyc - t0 < 1000);
    check(cyc - t0 == 128, "R9 duration kept", 32'(cyc - t0), 32'd128);
    bus_read(2'd1, s);
    check(s == 8'hC3, "R8 rx after done", {24'd0, s}, 32'hC3);
    rc0 = rc;
    repeat (50) @(negedge clk);
    bus_read(2'd0, s);
    check(s == 8'h08 && rc == rc0, "R9 no second exchange", {24'd0, s}, 32'h08);

    // R10 new byte used by next exchange; R6 strobe data 0xFF ignored
    xfer(8'h15, 8'h5E, 8'h00, 8'hFF, 1'b0);
    xfer(8'h16, 8'hFF, 8'hFF, 8'h13, 1'b1);

    // R11
    bus_read(2'd2, s);
    check(s == 8'h00, "R11 offset 2 read", {24'd0, s}, 32'h0);
    bus_read(2'd3, s);
    check(s == 8'h00, "R11 offset 3 read", {24'd0, s}, 32'h0);
    bus_read(2'd0, s);
    check(s == 8'h08, "R11 reads no side effect", {24'd0, s}, 32'h08);

    check(rc == 32, "R9 total sck pulses", 32'(rc), 32'd32);
    check(exp_q.size() == 0, "R3 scoreboard drained", 32'(exp_q.size()), 32'd0);
    check(mosi_viol == 0, "R4 mosi moved while sck high", 32'(mosi_viol), 32'd0);
    finished = 1'b1;
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL R7 watchdog actual=hung expected=finished");
      summary();
    end
  end
endmodule